// File: doc/BRIEF.md
# Memory Controller Event Statistics Counter

This block monitors the traffic that a memory arbiter grants and counts it. Each cycle the arbiter tells it whether a request was granted, which client won, the direction of the request, the three arbitration tags that came with it (high priority, timeout, bandwidth) and what the DRAM side saw for it (page miss, auto-precharge, bank AA or bank BB arbitration). Two independent gather channels each pick one kind of event, may restrict it to a single client, and may restrict it further to grants where a chosen tag is present or absent. A shared counter counts controller clocks over the same window, so software can later turn the event counts into utilisation figures.

Software runs it through a small register file. A global control register takes a two-bit command that resets, clears, disables or enables every counter together. After a disable command, the event counts and the clock count hold still and can be read out.

Top module: `mc_event_stats`

## Requirements
- R1: After reset, the global control, clock count, both gather controls and both gather counts read 0, the clock limit reads all ones, and gathering is off.
- R2: Writing the global control register at offset 0x90 with bits 9:8 = 3 turns gathering on from the next cycle. Bits 9:8 = 2 turns it off. While it is off, the counts and the clock count do not change.
- R3: While gathering is on, the clock count (offset 0xA4) goes up by one every cycle until it reaches the clock-limit register (offset 0xA0), and then stays there.
- R4: A gather control word (offset 0xA8 for gather 0, 0xAC for gather 1) selects its event in bits 23:16. The codes are 0 any granted request, 1 granted read (write input low), 2 granted write, 5 bank AA arbitration, 6 bank BB arbitration, 7 page miss and 8 auto-precharge. Any other code counts nothing. The counts read at 0xB8 and 0xBC.
- R5: When bit 26 of a gather control word is set, the gather counts only grants whose client ID equals bits 13:8. When bit 26 is clear, grants from all clients count.
- R6: Bits 25:24 choose a tag (0 high priority, 1 timeout, 2 bandwidth, 3 none). Bits 29:28 set the filter: 1 counts only when the chosen tag is low, 2 counts only when it is high, and 0 or 3 means no filter.
- R7: Event code 4 fires on a grant whose client equals the client of the previous grant, so N back-to-back grants to one client give N-1 events. Idle cycles between grants do not break the run.
- R8: Event code 3 fires on a grant whose direction differs from the direction of the previous grant.
- R9: The first grant after reset, a reset command or a clear command has no predecessor. It produces neither a code 3 nor a code 4 event.
- R10: Command 1 (clear) zeroes both counts and the clock count and leaves gathering as it was. Command 0 (reset) zeroes them and turns gathering off.
- R11: Event counts and the clock count are CNT_W bits wide. An event count stops at all ones and does not wrap.
- R12: Writes to the count registers are ignored. A gather control reads back only its defined fields (mask 0x37FF3F00), and an unmapped offset reads 0.
- R13: The two gathers count independently, each under its own control word, over the same stream of grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ev_grant | input | 1 | A request was granted this cycle |
| ev_client | input | CID_W | Client ID of the grant |
| ev_write | input | 1 | Granted request is a write |
| ev_hp | input | 1 | High-priority tag on the grant |
| ev_tm | input | 1 | Timeout tag on the grant |
| ev_bw | input | 1 | Bandwidth tag on the grant |
| ev_bank_aa | input | 1 | Bank AA arbitration on the grant |
| ev_bank_bb | input | 1 | Bank BB arbitration on the grant |
| ev_page_miss | input | 1 | Page miss on the grant |
| ev_auto_pre | input | 1 | Auto-precharge on the grant |

## Verification
The assertions check the counter dynamics on every cycle. The clock count steps by exactly one below its limit and freezes at it. Nothing moves while gathering is off. Event counts never decrease and never jump by more than one except through a command. Clear and reset commands leave every count at zero, and enable always turns gathering on. Whether each count is the right number of the right events can only be shown by the bench's scenarios. They sweep every event code, tag choice, filter mode and client-filter setting against an arithmetic model, and they cover the predecessor rule after reset and clear, saturation, and the clock limit.

// File: rtl/mc_event_stats.sv
module mc_event_stats #(
  parameter int CNT_W = 32,
  parameter int CID_W = 6,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_grant,
  input  logic [CID_W-1:0] ev_client,
  input  logic             ev_write,
  input  logic             ev_hp,
  input  logic             ev_tm,
  input  logic             ev_bw,
  input  logic             ev_bank_aa,
  input  logic             ev_bank_bb,
  input  logic             ev_page_miss,
  input  logic             ev_auto_pre
);
  localparam logic [AW-1:0] A_CTRL = AW'('h90);
  localparam logic [AW-1:0] A_LIM  = AW'('hA0);
  localparam logic [AW-1:0] A_CLK  = AW'('hA4);
  localparam logic [AW-1:0] A_G0   = AW'('hA8);
  localparam logic [AW-1:0] A_G1   = AW'('hAC);
  localparam logic [AW-1:0] A_C0   = AW'('hB8);
  localparam logic [AW-1:0] A_C1   = AW'('hBC);
  localparam logic [31:0] CTL_MASK = 32'h37FF_3F00;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             en;
  logic [1:0]       cmd_q;
  logic [CNT_W-1:0] limit, clocks;
  logic             have_prev, prev_write;
  logic [CID_W-1:0] prev_client;
  logic [1:0][31:0]      ctl_v;
  logic [1:0][CNT_W-1:0] cnt_v;

  wire       ctrl_wr = reg_wr && reg_addr == A_CTRL;
  wire [1:0] cmd     = reg_wdata[9:8];
  wire       wipe    = ctrl_wr && !cmd[1];
  wire       succ    = ev_grant && have_prev && ev_client == prev_client;
  wire       rwchg   = ev_grant && have_prev && ev_write != prev_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en          <= 1'b0;
      cmd_q       <= 2'd0;
      limit       <= CNT_MAX;
      clocks      <= '0;
      have_prev   <= 1'b0;
      prev_write  <= 1'b0;
      prev_client <= '0;
    end else begin
      if (ctrl_wr) begin
        cmd_q <= cmd;
        if (cmd == 2'd3)      en <= 1'b1;
        else if (cmd != 2'd1) en <= 1'b0;
      end
      if (reg_wr && reg_addr == A_LIM) limit <= reg_wdata[CNT_W-1:0];
      if (wipe)                         clocks <= '0;
      else if (en && clocks < limit)    clocks <= clocks + 1'b1;
      if (wipe) begin
        have_prev <= 1'b0;
      end else if (ev_grant) begin
        have_prev   <= 1'b1;
        prev_write  <= ev_write;
        prev_client <= ev_client;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_gather
    localparam logic [AW-1:0] A_MY = (g == 0) ? A_G0 : A_G1;
    logic [31:0]      ctl;
    logic [CNT_W-1:0] cnt;
    logic             raw, tag, hit;

    always_comb begin
      case (ctl[23:16])
        8'd0:    raw = ev_grant;
        8'd1:    raw = ev_grant && !ev_write;
        8'd2:    raw = ev_grant && ev_write;
        8'd3:    raw = rwchg;
        8'd4:    raw = succ;
        8'd5:    raw = ev_grant && ev_bank_aa;
        8'd6:    raw = ev_grant && ev_bank_bb;
        8'd7:    raw = ev_grant && ev_page_miss;
        8'd8:    raw = ev_grant && ev_auto_pre;
        default: raw = 1'b0;
      endcase
      case (ctl[25:24])
        2'd0:    tag = ev_hp;
        2'd1:    tag = ev_tm;
        2'd2:    tag = ev_bw;
        default: tag = 1'b0;
      endcase
    end

    assign hit = raw
               && (!ctl[26] || ev_client == ctl[8 +: CID_W])
               && (ctl[29:28] == 2'd1 ? !tag : ctl[29:28] == 2'd2 ? tag : 1'b1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl <= '0;
        cnt <= '0;
      end else begin
        if (reg_wr && reg_addr == A_MY) ctl <= reg_wdata & CTL_MASK;
        if (wipe)                              cnt <= '0;
        else if (en && hit && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
      end
    end

    assign ctl_v[g] = ctl;
    assign cnt_v[g] = cnt;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[9:8] = cmd_q;
      A_LIM:   reg_rdata[CNT_W-1:0] = limit;
      A_CLK:   reg_rdata[CNT_W-1:0] = clocks;
      A_G0:    reg_rdata = ctl_v[0];
      A_G1:    reg_rdata = ctl_v[1];
      A_C0:    reg_rdata[CNT_W-1:0] = cnt_v[0];
      A_C1:    reg_rdata[CNT_W-1:0] = cnt_v[1];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mc_event_stats_chk.sv
module mc_event_stats_chk #(
  parameter int CNT_W = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [1:0]       cmd,
  input logic             en,
  input logic [CNT_W-1:0] clocks,
  input logic [CNT_W-1:0] limit,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1
);
  localparam logic [AW-1:0] A_CTRL = AW'('h90);
  wire ctrl_wr = reg_wr && reg_addr == A_CTRL;

  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !ctrl_wr |=> $stable(cnt0) && $stable(cnt1) && $stable(clocks));

  p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && cmd == 2'd3 |=> en);

  p_clk_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en && clocks < limit && !ctrl_wr |=> clocks == CNT_W'($past(clocks) + 1'b1));

  p_clk_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clocks >= limit && !ctrl_wr |=> $stable(clocks));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !cmd[1] |=> cnt0 == '0 && cnt1 == '0 && clocks == '0);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> cnt0 >= $past(cnt0) && cnt1 >= $past(cnt1)
                 && cnt0 - $past(cnt0) <= 1 && cnt1 - $past(cnt1) <= 1);
endmodule

bind mc_event_stats mc_event_stats_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cmd(reg_wdata[9:8]), .en(en), .clocks(clocks), .limit(limit),
  .cnt0(cnt_v[0]), .cnt1(cnt_v[1])
);

// File: tb/test_mc_event_stats.sv
module test_mc_event_stats;
  localparam int CLK_P = 10;
  localparam int CNT_W = 8;
  localparam logic [7:0] A_CTRL = 8'h90, A_LIM = 8'hA0, A_CLK = 8'hA4,
                         A_G0 = 8'hA8, A_G1 = 8'hAC, A_C0 = 8'hB8, A_C1 = 8'hBC;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ev_grant = 0, ev_write = 0, ev_hp = 0, ev_tm = 0, ev_bw = 0;
  logic ev_bank_aa = 0, ev_bank_bb = 0, ev_page_miss = 0, ev_auto_pre = 0;
  logic [5:0] ev_client = '0;
  int n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  mc_event_stats #(.CNT_W(CNT_W), .CID_W(6), .AW(8)) i_mc_event_stats (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .ev_grant, .ev_client, .ev_write, .ev_hp, .ev_tm, .ev_bw,
    .ev_bank_aa, .ev_bank_bb, .ev_page_miss, .ev_auto_pre);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // flags: {write, hp, tm, bw, aa, bb, pm, ap}
  task automatic ev(input logic g, input logic [5:0] c, input logic [7:0] f);
    @(negedge clk);
    ev_grant = g; ev_client = c;
    {ev_write, ev_hp, ev_tm, ev_bw, ev_bank_aa, ev_bank_bb, ev_page_miss, ev_auto_pre} = f;
  endtask

  task automatic idle();
    @(negedge clk); ev_grant = 0;
  endtask

  function automatic int model(input logic [31:0] c, input logic g, input logic [5:0] cl,
                               input logic [7:0] f, input logic hv, input logic [5:0] pcl,
                               input logic pw);
    logic raw, tag;
    raw = 0;
    case (c[23:16])
      0: raw = g;
      1: raw = g && !f[7];
      2: raw = g && f[7];
      3: raw = g && hv && f[7] != pw;
      4: raw = g && hv && cl == pcl;
      5: raw = g && f[3];
      6: raw = g && f[2];
      7: raw = g && f[1];
      8: raw = g && f[0];
      default: raw = 0;
    endcase
    tag = (c[25:24] == 0) ? f[6] : (c[25:24] == 1) ? f[5] : (c[25:24] == 2) ? f[4] : 1'b0;
    if (c[26] && cl != c[13:8]) raw = 0;
    if (c[29:28] == 1 && tag) raw = 0;
    if (c[29:28] == 2 && !tag) raw = 0;
    return raw ? 1 : 0;
  endfunction

  task automatic run_case(input logic [31:0] c0, input logic [31:0] c1, input int n);
    int e0 = 0, e1 = 0;
    logic hv = 0, pw = 0;
    logic [5:0] pcl = 0;
    logic [31:0] r;
    wr(A_CTRL, 32'h0); wr(A_G0, c0); wr(A_G1, c1); wr(A_CTRL, 32'h300);
    for (int i = 0; i < n; i++) begin
      logic g;
      logic [5:0] cl;
      logic [7:0] f;
      g  = (i % 5) != 3;
      cl = 6'((i / 3) % 4);
      f  = {((i * 7) % 3) == 0, (i % 2) == 1, (i % 3) == 1, (i % 4) >= 2,
            (i % 6) == 0, (i % 7) == 2, (i % 3) == 2, (i % 5) == 1};
      ev(g, cl, f);
      e0 += model(c0, g, cl, f, hv, pcl, pw);
      e1 += model(c1, g, cl, f, hv, pcl, pw);
      if (g) begin hv = 1; pcl = cl; pw = f[7]; end
    end
    idle();
    wr(A_CTRL, 32'h200);
    rd(A_C0, r); check("R4 R5 R6 R7 R8 sweep gather0", r, 32'(e0));
    rd(A_C1, r); check("R13 sweep gather1", r, 32'(e1));
  endtask

  task automatic clk_case(input int lim, input int k);
    logic [31:0] r;
    int exp;
    wr(A_LIM, 32'(lim)); wr(A_CTRL, 32'h0); wr(A_CTRL, 32'h300);
    repeat (k) @(negedge clk);
    wr(A_CTRL, 32'h200);
    exp = (k + 2 < lim) ? k + 2 : lim;
    rd(A_CLK, r); check("R3 clock count", r, 32'(exp));
    repeat (5) @(negedge clk);
    rd(A_CLK, r); check("R2 clock held when off", r, 32'(exp));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_CTRL, r); check("R1 ctrl", r, 32'h0);
    rd(A_LIM, r);  check("R1 limit", r, 32'hFF);
    rd(A_CLK, r);  check("R1 clocks", r, 32'h0);
    rd(A_G0, r);   check("R1 gctl0", r, 32'h0);
    rd(A_G1, r);   check("R1 gctl1", r, 32'h0);
    rd(A_C0, r);   check("R1 count0", r, 32'h0);
    rd(A_C1, r);   check("R1 count1", r, 32'h0);
    // R12 register map behaviour
    wr(A_C0, 32'h55); rd(A_C0, r); check("R12 count write ignored", r, 32'h0);
    wr(A_CLK, 32'h33); rd(A_CLK, r); check("R12 clock write ignored", r, 32'h0);
    wr(A_G0, 32'hFFFF_FFFF); rd(A_G0, r); check("R12 gctl mask", r, 32'h37FF_3F00);
    rd(8'h00, r); check("R12 unmapped", r, 32'h0);
    // R3 clock counter and limit
    clk_case(255, 0);
    clk_case(255, 3);
    clk_case(255, 40);
    clk_case(255, 400);
    clk_case(20, 50);
    clk_case(1, 10);
    wr(A_LIM, 32'hFF);
    // R4 R5 R6 R7 R8 R13 sweep
    for (int code = 0; code < 10; code++)
      for (int ps = 0; ps < 3; ps++)
        for (int pf = 0; pf < 4; pf++)
          for (int ce = 0; ce < 2; ce++) begin
            logic [31:0] c0, c1;
            c0 = (32'(pf) << 28) | (32'(ce) << 26) | (32'(ps) << 24) | (32'(code) << 16) | (32'd2 << 8);
            c1 = (32'(3 - pf) << 28) | (32'(1 - ce) << 26) | (32'(2 - ps) << 24)
               | (32'((code + 3) % 10) << 16) | (32'd1 << 8);
            run_case(c0, c1, 30);
          end
    // R9 first grant has no predecessor
    wr(A_CTRL, 32'h0); wr(A_G0, 32'h0004_0000); wr(A_G1, 32'h0003_0000); wr(A_CTRL, 32'h300);
    repeat (3) ev(1, 6'd5, 8'h80);
    idle();
    rd(A_C0, r); check("R7 successive N-1", r, 32'd2);
    rd(A_C1, r); check("R9 no change on first write", r, 32'd0);
    wr(A_CTRL, 32'h100);
    ev(1, 6'd5, 8'h00); idle();
    rd(A_C0, r); check("R9 no successive after clear", r, 32'd0);
    rd(A_C1, r); check("R9 no change after clear", r, 32'd0);
    ev(1, 6'd5, 8'h80); idle();
    rd(A_C0, r); check("R7 successive after clear", r, 32'd1);
    rd(A_C1, r); check("R8 change after clear", r, 32'd1);
    // R10 clear keeps gathering on, reset turns it off
    wr(A_CTRL, 32'h0); wr(A_G0, 32'h0); wr(A_G1, 32'h0400_3F00); wr(A_CTRL, 32'h300);
    repeat (5) ev(1, 6'd1, 8'h00);
    idle();
    wr(A_CTRL, 32'h100);
    rd(A_C0, r); check("R10 clear zeroes", r, 32'd0);
    repeat (3) ev(1, 6'd1, 8'h00);
    idle();
    rd(A_C0, r); check("R10 counting after clear", r, 32'd3);
    wr(A_CTRL, 32'h0);
    rd(A_C0, r); check("R10 reset zeroes", r, 32'd0);
    repeat (4) ev(1, 6'd1, 8'h00);
    idle();
    rd(A_C0, r); check("R10 reset disables", r, 32'd0);
    rd(A_CLK, r); check("R10 reset clocks", r, 32'd0);
    // R2 disable holds counts
    wr(A_CTRL, 32'h300);
    repeat (6) ev(1, 6'd2, 8'h00);
    idle();
    wr(A_CTRL, 32'h200);
    repeat (6) ev(1, 6'd2, 8'h00);
    idle();
    rd(A_C0, r); check("R2 held after disable", r, 32'd6);
    rd(A_CTRL, r); check("R2 ctrl readback", r, 32'h200);
    // R11 saturation
    wr(A_CTRL, 32'h0); wr(A_CTRL, 32'h300);
    repeat (300) ev(1, 6'd3, 8'h00);
    idle();
    wr(A_CTRL, 32'h200);
    rd(A_C0, r); check("R11 count saturates", r, 32'hFF);
    rd(A_C1, r); check("R5 client filter none match", r, 32'd0);
    rd(A_CLK, r); check("R3 clock at limit", r, 32'hFF);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule